// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Compare Preload

This block is one channel of a general-purpose timer. A direction field picks its role. As an output, it compares the timer's up-counter with an active compare value and drives a pulse-width output. As an input, it latches the counter value when a chosen edge arrives on its capture pin. The counter, the prescaler and any interrupt or DMA logic sit outside the block. The block receives the counter value and a one-cycle update-event pulse from the surrounding timer.

Writes to the compare value can take effect at once, or they can wait in a shadow register until the next update event, so that a PWM period never runs on a half-changed setting. For one-pulse use there is a fast trigger path. A synchronised rising edge on the trigger input acts like a compare match and forces the output to its active level, whatever the comparison says. This cuts the trigger-to-output latency to three clocks. Software reaches the channel through a small four-word register port with a combinational read.

Top module: `tccx_channel`

## Requirements
- R1: After reset, every register reads 0 and `ch_out` is 0. The channel starts as a disabled output, with preload off and output mode 0.
- R2: Register map, addressed by `reg_addr`.
  - Address 0, MODE: bits[1:0] direction (00 output, 01 capture input, 10/11 reserved and inert), bit2 fast enable, bit3 preload enable, bits[5:4] output mode (00 inactive, 01 forced active, 10 PWM1, 11 PWM2).
  - Address 1, CTRL: bit0 enable, bit1 polarity P, bit2 polarity NP, bit3 capture flag.
  - Address 2: compare value.
  - Address 3: active compare value, read-only.
  - With preload enable 0, a write to address 2 updates the active compare value at once, and the next comparison uses it.
- R3: With preload enable 1, address 2 reads and writes only the shadow register. The active value changes only on a cycle with `upd_evt` high, which copies the shadow value held before that edge.
- R4: In PWM1 mode, with the channel enabled as an output, `ch_out` is active one clock after a cycle in which `cnt_val` < active compare, and inactive otherwise.
- R5: In PWM2 mode, `ch_out` is active one clock after a cycle in which `cnt_val` >= active compare.
- R6: In output mode, P=1 makes the active level low. When enable is 0, `ch_out` is 0 from the next clock on.
- R7: With fast enable set and output mode PWM1 or PWM2, a rising edge on `trig_in` drives `ch_out` active on the third rising clock edge after the edge, whatever the comparison gives. The output stays active until an update event.
- R8: In output modes 00 and 01, fast enable has no effect, and a trigger edge leaves `ch_out` unchanged.
- R9: A write to MODE changes the direction field only when enable is 0 before the write. At other times the direction bits of the write are ignored.
- R10: In capture mode, the two polarity bits {NP,P} select the captured edge of `cap_in`: 00 rising, 01 falling, 11 both, 10 rising. The capture takes place on the third rising clock edge after the pin edge. `ch_out` is 0 in capture mode.
- R11: A capture copies `cnt_val` into both the active and the shadow compare registers and sets the capture flag (CTRL bit3). Writing CTRL with bit3 set clears the flag. A capture in the same cycle as such a clear wins.
- R12: While the direction is output, CTRL bit2 (NP) reads as 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data (combinational) |
| cnt_val | input | CNT_W | Timer counter value |
| upd_evt | input | 1 | Update event pulse |
| trig_in | input | 1 | Trigger input (asynchronous) |
| cap_in | input | 1 | Capture input (asynchronous) |
| ch_out | output | 1 | Registered channel output |

## Verification
The bench builds the channel with `CNT_W` = 8. At that width the extremes of the compare range are cheap to reach:
- a compare value of 0, where PWM1 is never active and PWM2 is always active;
- a counter of 255, the top of the range.

The synchroniser depth keeps its default of two. This pins the trigger-to-output and pin-to-capture delays at exactly three clocks, and the bench checks those delays cycle by cycle.

// File: rtl/tccx_pkg.sv
package tccx_pkg;

  typedef enum logic [1:0] {
    DIR_OUT  = 2'b00,
    DIR_IN   = 2'b01,
    DIR_RSV2 = 2'b10,
    DIR_RSV3 = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    OM_INACT = 2'b00,
    OM_FORCE = 2'b01,
    OM_PWM1  = 2'b10,
    OM_PWM2  = 2'b11
  } omode_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_ACT  = 2'd3;

  localparam int MAX_W = 32;

  // Raw compare result for the selected output mode, before polarity.
  function automatic logic pwm_active(omode_e m, logic [MAX_W-1:0] cnt,
                                      logic [MAX_W-1:0] cmp);
    case (m)
      OM_INACT: return 1'b0;
      OM_FORCE: return 1'b1;
      OM_PWM1:  return cnt < cmp;
      default:  return cnt >= cmp;
    endcase
  endfunction

  // Edge qualification from the {np,p} pair.
  function automatic logic edge_hit(logic np, logic p, logic rise, logic fall);
    case ({np, p})
      2'b01:   return fall;
      2'b11:   return rise | fall;
      default: return rise;
    endcase
  endfunction

  function automatic logic is_pwm(omode_e m);
    return (m == OM_PWM1) || (m == OM_PWM2);
  endfunction

endpackage

// File: rtl/tccx_edge_sync.sv
module tccx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] sh_q;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b0;
          else        sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign rise = sh_q[LAST] & ~sh_q[STAGES];
  assign fall = ~sh_q[LAST] & sh_q[STAGES];
endmodule

// File: rtl/tccx_cfg_regs.sv
module tccx_cfg_regs
  import tccx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             upd_evt,
  input  logic             cap_evt,
  output dir_e             dir,
  output omode_e           omode,
  output logic             fast_en,
  output logic             pre_en,
  output logic             en,
  output logic             pol_p,
  output logic             pol_np,
  output logic             cap_flag,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] cmp_shd
);
  logic wr_mode, wr_ctrl, wr_cmp;
  logic np_raw;

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cmp  = reg_wr && (reg_addr == A_CMP);

  // MODE register; direction locked while enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= DIR_OUT;
      fast_en <= 1'b0;
      pre_en  <= 1'b0;
      omode   <= OM_INACT;
    end else if (wr_mode) begin
      if (!en) dir <= dir_e'(reg_wdata[1:0]);
      fast_en <= reg_wdata[2];
      pre_en  <= reg_wdata[3];
      omode   <= omode_e'(reg_wdata[5:4]);
    end
  end

  // CTRL register and capture flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      pol_p    <= 1'b0;
      np_raw   <= 1'b0;
      cap_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en     <= reg_wdata[0];
        pol_p  <= reg_wdata[1];
        np_raw <= reg_wdata[2];
        if (reg_wdata[3]) cap_flag <= 1'b0;
      end
      if (cap_evt) cap_flag <= 1'b1;
    end
  end

  assign pol_np = (dir == DIR_IN) & np_raw;

  // Compare shadow / active pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
      cmp_shd <= '0;
    end else if (cap_evt) begin
      cmp_act <= cnt_val;
      cmp_shd <= cnt_val;
    end else begin
      if (wr_cmp) begin
        cmp_shd <= reg_wdata;
        if (!pre_en) cmp_act <= reg_wdata;
      end
      if (upd_evt && pre_en) cmp_act <= cmp_shd;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: reg_rdata[5:0] = {omode, pre_en, fast_en, dir};
      A_CTRL: reg_rdata[3:0] = {cap_flag, pol_np, pol_p, en};
      A_CMP:  reg_rdata      = pre_en ? cmp_shd : cmp_act;
      default: reg_rdata     = cmp_act;
    endcase
  end
endmodule

// File: rtl/tccx_oc_gen.sv
module tccx_oc_gen
  import tccx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_en,
  input  omode_e           omode,
  input  logic             pol_p,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             trig_evt,
  input  logic             upd_evt,
  output logic             ch_out
);
  logic force_q;
  logic level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        force_q <= 1'b0;
    else if (trig_evt) force_q <= 1'b1;
    else if (upd_evt || !drive_en) force_q <= 1'b0;
  end

  assign level = pwm_active(omode, MAX_W'(cnt_val), MAX_W'(cmp_act))
               | trig_evt | (force_q & ~upd_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_out <= 1'b0;
    else        ch_out <= drive_en & (level ^ pol_p);
  end
endmodule

// File: rtl/tccx_channel.sv
module tccx_channel
  import tccx_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             upd_evt,
  input  logic             trig_in,
  input  logic             cap_in,
  output logic             ch_out
);
  dir_e             dir_w;
  omode_e           omode_w;
  logic             fast_w, pre_w, en_w, pol_p_w, pol_np_w, flag_w;
  logic [CNT_W-1:0] cmp_act_w, cmp_shd_w;
  logic             trig_rise, trig_fall_unused;
  logic             cap_rise, cap_fall;
  logic             trig_evt, cap_evt, out_drive;

  tccx_edge_sync #(.STAGES(SYNC_DEPTH)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in),
    .rise(trig_rise), .fall(trig_fall_unused)
  );

  tccx_edge_sync #(.STAGES(SYNC_DEPTH)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in),
    .rise(cap_rise), .fall(cap_fall)
  );

  assign out_drive = en_w && (dir_w == DIR_OUT);
  assign trig_evt  = out_drive && fast_w && is_pwm(omode_w) && trig_rise;
  assign cap_evt   = en_w && (dir_w == DIR_IN)
                   && edge_hit(pol_np_w, pol_p_w, cap_rise, cap_fall);

  tccx_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_val(cnt_val), .upd_evt(upd_evt),
    .cap_evt(cap_evt), .dir(dir_w), .omode(omode_w), .fast_en(fast_w),
    .pre_en(pre_w), .en(en_w), .pol_p(pol_p_w), .pol_np(pol_np_w),
    .cap_flag(flag_w), .cmp_act(cmp_act_w), .cmp_shd(cmp_shd_w)
  );

  tccx_oc_gen #(.CNT_W(CNT_W)) u_oc (
    .clk(clk), .rst_n(rst_n), .drive_en(out_drive), .omode(omode_w),
    .pol_p(pol_p_w), .cnt_val(cnt_val), .cmp_act(cmp_act_w),
    .trig_evt(trig_evt), .upd_evt(upd_evt), .ch_out(ch_out)
  );
endmodule

// File: rtl/tccx_channel_chk.sv
module tccx_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_w,
  input logic [1:0]       dir_w,
  input logic             pre_w,
  input logic [CNT_W-1:0] cmp_act_w,
  input logic [CNT_W-1:0] cmp_shd_w,
  input logic             upd_evt,
  input logic             cap_evt,
  input logic             flag_w,
  input logic             ch_out
);
  // R6: a disabled channel drives 0 on the following clock
  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |=> !ch_out);

  // R10: capture or reserved direction keeps the output low
  p_in_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_w != 2'b00) |=> !ch_out);

  // R3: with preload on, active compare only moves on update or capture
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_w && !upd_evt && !cap_evt) |=> $stable(cmp_act_w));

  // R3: update copies the prior shadow value
  p_upd_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_w && upd_evt && !cap_evt) |=> (cmp_act_w == $past(cmp_shd_w)));

  // R9: direction frozen while enabled
  p_dir_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |=> $stable(dir_w));

  // R11: capture sets the flag
  p_cap_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_w);
endmodule

bind tccx_channel tccx_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_w(en_w), .dir_w(dir_w), .pre_w(pre_w),
  .cmp_act_w(cmp_act_w), .cmp_shd_w(cmp_shd_w), .upd_evt(upd_evt),
  .cap_evt(cap_evt), .flag_w(flag_w), .ch_out(ch_out)
);

// File: tb/tccx_channel_tb.sv
module tccx_channel_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] cnt_val = '0;
  logic         upd_evt = 1'b0;
  logic         trig_in = 1'b0;
  logic         cap_in = 1'b0;
  logic         ch_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tccx_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_val(cnt_val),
    .upd_evt(upd_evt), .trig_in(trig_in), .cap_in(cap_in), .ch_out(ch_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, int exp);
    reg_addr = a;
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic out_chk(string tag, logic [W-1:0] c, int exp);
    cnt_val = c;
    @(negedge clk);
    chk(tag, int'(ch_out), exp);
  endtask

  task automatic pulse_upd();
    upd_evt = 1'b1;
    @(negedge clk);
    upd_evt = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trig_in = 1'b0; cap_in = 1'b0; upd_evt = 1'b0; cnt_val = '0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 out", int'(ch_out), 0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reg", 2'(a), 0);
  endtask

  task automatic t_preload_off();
    wr(2'd0, 8'h20);            // PWM1, preload off
    wr(2'd1, 8'h01);
    wr(2'd2, 8'd100);
    rd_chk("R2 active", 2'd3, 100);
    out_chk("R2 below", 8'd99, 1);
    out_chk("R2 equal", 8'd100, 0);
    wr(2'd2, 8'd50);
    out_chk("R2 new value at once", 8'd60, 0);
    out_chk("R4 below new", 8'd49, 1);
  endtask

  task automatic t_preload_on();
    wr(2'd0, 8'h28);            // PWM1, preload on
    wr(2'd2, 8'd200);
    rd_chk("R3 active held", 2'd3, 50);
    rd_chk("R3 shadow read", 2'd2, 200);
    out_chk("R3 old compare used", 8'd150, 0);
    pulse_upd();
    rd_chk("R3 active after update", 2'd3, 200);
    out_chk("R3 new compare used", 8'd150, 1);
  endtask

  task automatic t_pwm_edges();
    wr(2'd0, 8'h20);
    wr(2'd2, 8'd0);
    out_chk("R4 cmp0 never active", 8'd0, 0);
    out_chk("R4 cnt max", 8'd255, 0);
    wr(2'd0, 8'h30);            // PWM2
    out_chk("R5 cmp0 always active", 8'd0, 1);
    wr(2'd2, 8'd128);
    out_chk("R5 below", 8'd127, 0);
    out_chk("R5 equal", 8'd128, 1);
    out_chk("R5 top", 8'd255, 1);
  endtask

  task automatic t_polarity();
    wr(2'd0, 8'h20);
    wr(2'd2, 8'd100);
    wr(2'd1, 8'h03);            // enable, active low
    out_chk("R6 inverted active", 8'd50, 0);
    out_chk("R6 inverted idle", 8'd150, 1);
    wr(2'd1, 8'h02);            // disabled
    out_chk("R6 disabled", 8'd150, 0);
  endtask

  task automatic t_fast();
    do_reset();
    wr(2'd0, 8'h24);            // PWM1 + fast
    wr(2'd1, 8'h01);
    cnt_val = 8'd5;             // compare 0 -> level inactive
    step(1);
    chk("R7 idle", int'(ch_out), 0);
    trig_in = 1'b1;
    step(2);
    chk("R7 not yet after 2 clocks", int'(ch_out), 0);
    step(1);
    chk("R7 active after 3 clocks", int'(ch_out), 1);
    trig_in = 1'b0;
    step(3);
    chk("R7 held", int'(ch_out), 1);
    pulse_upd();
    chk("R7 released by update", int'(ch_out), 0);
  endtask

  task automatic t_fast_ignored();
    wr(2'd0, 8'h04);            // inactive mode + fast
    trig_in = 1'b1;
    step(5);
    chk("R8 no force", int'(ch_out), 0);
    trig_in = 1'b0;
    step(3);
  endtask

  task automatic t_dir_np();
    wr(2'd1, 8'h05);            // enable + NP in output mode
    rd_chk("R12 NP masked", 2'd1, 1);
    wr(2'd0, 8'h01);
    rd_chk("R9 dir locked", 2'd0, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    rd_chk("R9 dir written", 2'd0, 1);
    wr(2'd1, 8'h04);
    rd_chk("R12 NP kept in input", 2'd1, 4);
  endtask

  task automatic t_capture();
    // direction already input; falling edge
    wr(2'd1, 8'h03);
    cnt_val = 8'd42;
    cap_in = 1'b1;
    step(4);
    rd_chk("R10 rise ignored when falling", 2'd1, 3);
    chk("R10 output low", int'(ch_out), 0);
    cap_in = 1'b0;
    step(2);
    rd_chk("R10 capture not before 3 clocks", 2'd1, 3);
    step(1);
    rd_chk("R11 flag set", 2'd1, 11);
    rd_chk("R11 value latched", 2'd3, 42);
    wr(2'd1, 8'h0B);
    rd_chk("R11 flag cleared", 2'd1, 3);
    // both edges
    wr(2'd1, 8'h07);
    cnt_val = 8'd77;
    cap_in = 1'b1;
    step(4);
    rd_chk("R10 both rise", 2'd3, 77);
    wr(2'd1, 8'h0F);
    cnt_val = 8'd88;
    cap_in = 1'b0;
    step(4);
    rd_chk("R10 both fall flag", 2'd1, 15);
    rd_chk("R10 both fall value", 2'd3, 88);
    // rising only
    wr(2'd1, 8'h09);
    cnt_val = 8'd9;
    cap_in = 1'b1;
    step(4);
    rd_chk("R10 rising", 2'd3, 9);
    rd_chk("R11 shadow also captured", 2'd2, 9);
  endtask

  initial begin
    t_reset();
    t_preload_off();
    t_preload_on();
    t_pwm_edges();
    t_polarity();
    t_fast();
    t_fast_ignored();
    t_dir_np();
    t_capture();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule